// File: doc/BRIEF.md
# Energy metering RMS accumulator

This block takes paired signed voltage and current samples, one pair for each strobe on `smp_valid`. It collects them into computation cycles of N pairs. Over each cycle it sums the squared voltage, the squared current and the voltage-current products. When the Nth pair of a cycle arrives, a four-state post-processing engine takes over. It runs a sequential divider and a bit-serial integer square root, then posts four results at once: unsigned RMS voltage, unsigned RMS current, signed average real power, and signed cycle energy.

A host uses a small register port to read results, set the cycle count N, set the interrupt mask and clear the two status flags. The status register has two sticky flags. One marks every new sample pair and one marks every set of posted results. The `irq` output goes high while any flag is set and enabled in the mask.

The engine has four states:
- S_IDLE waits for the end of a cycle. The end of a cycle takes it to S_DIV and starts three dividers.
- S_DIV waits for the dividers. When they finish it moves to S_ROOT and starts two square roots.
- S_ROOT waits for the roots. When they finish it moves to S_POST.
- S_POST writes all four result registers and the data-ready flag in one clock, then returns to S_IDLE.

Top module: `rms_meter`

Register map (`reg_addr`):

| Address | Register | Access |
|---|---|---|
| 0 | status: bit0 conversion-ready, bit1 data-ready | write-one-to-clear |
| 1 | mask, bits 1:0 | read/write |
| 2 | cycle count N | read/write |
| 3 | RMS voltage | read |
| 4 | RMS current | read |
| 5 | average power | read |
| 6 | energy | read |
| 7 | reads zero | read |

Samples are SW-bit two's complement fractions. In the unsigned results the most significant bit is always zero.

## Requirements
- R1: After reset the registers hold these values: status 0, mask 0, all four results 0, and cycle count DEF_N. `irq` is low.
- R2: Status bit0 (conversion-ready) is set on the clock edge that samples `smp_valid` high.
- R3: Status bit1 (data-ready) sets only after the Nth pair of a cycle has arrived. It sets no more than 2*SW+NW+SW+8 clocks after that pair.
- R4: Both status bits are sticky. A write to address 0 clears each bit that has a 1 in `reg_wdata` and leaves each bit that has a 0. When a set and a clear of the same bit fall in one clock, the set wins.
- R5: `irq` is high exactly when some status bit is set and its mask bit is set. The mask bit positions match the status bit positions.
- R6: RMS voltage is floor(sqrt(floor(S/N))), where S is the sum of the squares of the raw integer samples over the cycle. RMS current uses the same formula. Each result saturates at 2^(SW-1)-1.
- R7: Average power is the sum P of the raw voltage-current products, divided by N and then by 2^(SW-1). Both divisions truncate toward zero. The magnitude saturates at 2^(SW-1)-1, and the result is written as SW-bit two's complement.
- R8: Energy is sign(P)*min(floor(|P|/2^(SW-1+E_SHIFT)), 2^(SW-1)-1), written as SW-bit two's complement.
- R9: With N=1, every sample pair produces posted results and sets data-ready.
- R10: A write to address 2 is used from the next cycle boundary onward. The cycle in progress keeps its N. Writing 0 stores 1. A value above the field width stores the largest count.
- R11: All four results and data-ready update in the same clock. Between posts the results stay unchanged, and each cycle starts from zero sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Conversion strobe; one sample pair per high cycle |
| v_smp | input | SW | Voltage sample, two's complement |
| i_smp | input | SW | Current sample, two's complement |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | SW | Register write data |
| reg_rdata | output | SW | Register read data for reg_addr, combinational |
| irq | output | 1 | Interrupt: any enabled status bit set |

## Verification
The bench builds the block with SW=24, NW=16, DEF_N=4 and E_SHIFT=0. The short default cycle lets it run many complete cycles, the change from a 4-pair cycle to a 3-pair cycle, and the N=1 instantaneous mode within a short run. With E_SHIFT=0 energy is the full product sum scaled by 2^23. That value reaches saturation at full-scale input with only four pairs, alongside the saturated RMS and power results.

// File: rtl/rms_pkg.sv
package rms_pkg;
    typedef enum logic [2:0] {
        A_STAT = 3'd0,
        A_MASK = 3'd1,
        A_CYC  = 3'd2,
        A_VRMS = 3'd3,
        A_IRMS = 3'd4,
        A_POWR = 3'd5,
        A_ENGY = 3'd6,
        A_NONE = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DIV,
        S_ROOT,
        S_POST
    } eng_state_e;
endpackage

// File: rtl/rms_accum.sv
module rms_accum #(
    parameter int SW    = 24,
    parameter int NW    = 16,
    parameter int AW    = 64,
    parameter int DEF_N = 4000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [SW-1:0] v_smp,
    input  logic signed [SW-1:0] i_smp,
    input  logic [NW-1:0]        n_next,
    output logic                 cyc_end,
    output logic [AW-1:0]        sum_vv,
    output logic [AW-1:0]        sum_ii,
    output logic [AW-1:0]        sum_vi,
    output logic [NW-1:0]        n_used
);
    localparam int PW = 2 * SW;

    logic signed [PW-1:0] p_vv, p_ii, p_vi;
    logic [AW-1:0] acc_vv, acc_ii, acc_vi;
    logic [AW-1:0] nx_vv, nx_ii, nx_vi;
    logic [NW-1:0] cnt, n_cur;

    always_comb begin
        p_vv  = v_smp * v_smp;
        p_ii  = i_smp * i_smp;
        p_vi  = v_smp * i_smp;
        nx_vv = acc_vv + {{(AW-PW){1'b0}}, p_vv};
        nx_ii = acc_ii + {{(AW-PW){1'b0}}, p_ii};
        nx_vi = acc_vi + {{(AW-PW){p_vi[PW-1]}}, p_vi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_vv  <= '0;
            acc_ii  <= '0;
            acc_vi  <= '0;
            sum_vv  <= '0;
            sum_ii  <= '0;
            sum_vi  <= '0;
            cnt     <= '0;
            n_cur   <= NW'(DEF_N);
            n_used  <= NW'(DEF_N);
            cyc_end <= 1'b0;
        end else begin
            cyc_end <= 1'b0;
            if (smp_valid) begin
                if (cnt == n_cur - 1'b1) begin
                    sum_vv  <= nx_vv;
                    sum_ii  <= nx_ii;
                    sum_vi  <= nx_vi;
                    n_used  <= n_cur;
                    acc_vv  <= '0;
                    acc_ii  <= '0;
                    acc_vi  <= '0;
                    cnt     <= '0;
                    n_cur   <= n_next;
                    cyc_end <= 1'b1;
                end else begin
                    acc_vv <= nx_vv;
                    acc_ii <= nx_ii;
                    acc_vi <= nx_vi;
                    cnt    <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rms_div.sv
module rms_div #(
    parameter int W  = 64,
    parameter int DW = 16,
    parameter int QW = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  dividend,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [QW-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    logic [DW-1:0] rem, dsr;
    logic [W-1:0]  quo;
    logic [CW-1:0] cnt;
    logic          run;
    logic [DW:0]   shl, dif;
    logic          ge;

    always_comb begin
        shl = {rem, quo[W-1]};
        dif = shl - {1'b0, dsr};
        ge  = (shl >= {1'b0, dsr});
    end

    assign quotient = quo[QW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem  <= '0;
            dsr  <= '0;
            quo  <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem <= '0;
                quo <= dividend;
                dsr <= divisor;
                cnt <= CW'(W);
                run <= 1'b1;
            end else if (run) begin
                rem <= ge ? dif[DW-1:0] : shl[DW-1:0];
                quo <= {quo[W-2:0], ge};
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rms_isqrt.sv
module rms_isqrt #(
    parameter int OW = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2*OW-1:0] rad,
    output logic            done,
    output logic [OW-1:0]   root
);
    localparam int CW = $clog2(OW + 1);

    logic [2*OW-1:0] x;
    logic [OW+1:0]   rem;
    logic [OW+3:0]   rsh, trial, dif;
    logic [CW-1:0]   cnt;
    logic            run, ge;

    always_comb begin
        rsh   = {rem, x[2*OW-1:2*OW-2]};
        trial = {2'b00, root, 2'b01};
        dif   = rsh - trial;
        ge    = (rsh >= trial);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x    <= '0;
            rem  <= '0;
            root <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                x    <= rad;
                rem  <= '0;
                root <= '0;
                cnt  <= CW'(OW);
                run  <= 1'b1;
            end else if (run) begin
                rem  <= ge ? dif[OW+1:0] : rsh[OW+1:0];
                root <= {root[OW-2:0], ge};
                x    <= {x[2*OW-3:0], 2'b00};
                cnt  <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rms_meter.sv
module rms_meter
    import rms_pkg::*;
#(
    parameter int SW      = 24,
    parameter int NW      = 16,
    parameter int DEF_N   = 4000,
    parameter int E_SHIFT = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [SW-1:0] v_smp,
    input  logic signed [SW-1:0] i_smp,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_addr,
    input  logic [SW-1:0]        reg_wdata,
    output logic [SW-1:0]        reg_rdata,
    output logic                 irq
);
    localparam int AW = 2 * SW + NW;
    localparam int MW = 2 * SW;
    localparam logic [MW-1:0] FMAX = MW'((64'd1 << (SW - 1)) - 64'd1);

    eng_state_e st, nx;
    logic          cyc_end, div_start, sq_start, post;
    logic [AW-1:0] sum_vv, sum_ii, sum_vi, abs_vi, eabs;
    logic [NW-1:0] n_used;
    logic          p_neg;
    logic [AW-1:0] num [3];
    logic [MW-1:0] quo [3];
    logic [2:0]    dv_done;
    logic [SW-1:0] rt  [2];
    logic [1:0]    sq_done;
    logic [1:0]    stat_q, mask_q, clr;
    logic [NW-1:0] cyc_q;
    logic [SW-1:0] vrms_q, irms_q, powr_q, engy_q;
    logic [MW-1:0] pm, em, vsat, isat;
    logic [AW-1:0] e_sh;

    rms_accum #(.SW(SW), .NW(NW), .AW(AW), .DEF_N(DEF_N)) u_acc (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .v_smp(v_smp), .i_smp(i_smp), .n_next(cyc_q),
        .cyc_end(cyc_end), .sum_vv(sum_vv), .sum_ii(sum_ii),
        .sum_vi(sum_vi), .n_used(n_used)
    );

    assign abs_vi = sum_vi[AW-1] ? (~sum_vi + 1'b1) : sum_vi;
    assign num[0] = sum_vv;
    assign num[1] = sum_ii;
    assign num[2] = abs_vi;

    for (genvar k = 0; k < 3; k++) begin : g_div
        rms_div #(.W(AW), .DW(NW), .QW(MW)) u_div (
            .clk(clk), .rst_n(rst_n), .start(div_start),
            .dividend(num[k]), .divisor(n_used),
            .done(dv_done[k]), .quotient(quo[k])
        );
    end

    for (genvar k = 0; k < 2; k++) begin : g_sqrt
        rms_isqrt #(.OW(SW)) u_sq (
            .clk(clk), .rst_n(rst_n), .start(sq_start),
            .rad(quo[k]), .done(sq_done[k]), .root(rt[k])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nx;
    end

    // transitions and strobes
    always_comb begin
        nx        = st;
        div_start = 1'b0;
        sq_start  = 1'b0;
        post      = 1'b0;
        unique case (st)
            S_IDLE: if (cyc_end) begin
                nx        = S_DIV;
                div_start = 1'b1;
            end
            S_DIV: if (dv_done[0]) begin
                nx       = S_ROOT;
                sq_start = 1'b1;
            end
            S_ROOT: if (sq_done[0]) nx = S_POST;
            S_POST: begin
                nx   = S_IDLE;
                post = 1'b1;
            end
            default: nx = S_IDLE;
        endcase
    end

    always_comb begin
        vsat = {{(MW-SW){1'b0}}, rt[0]};
        isat = {{(MW-SW){1'b0}}, rt[1]};
        if (vsat > FMAX) vsat = FMAX;
        if (isat > FMAX) isat = FMAX;
        pm = quo[2] >> (SW - 1);
        if (pm > FMAX) pm = FMAX;
        e_sh = eabs >> (SW - 1 + E_SHIFT);
        em   = (e_sh > AW'(FMAX)) ? FMAX : e_sh[MW-1:0];
        clr  = (reg_wr && reg_addr == A_STAT) ? reg_wdata[1:0] : 2'b00;
    end

    // outputs and registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '0;
            cyc_q  <= NW'(DEF_N);
            vrms_q <= '0;
            irms_q <= '0;
            powr_q <= '0;
            engy_q <= '0;
            eabs   <= '0;
            p_neg  <= 1'b0;
        end else begin
            stat_q <= (stat_q & ~clr) | {post, smp_valid};
            if (div_start) begin
                eabs  <= abs_vi;
                p_neg <= sum_vi[AW-1];
            end
            if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata[1:0];
            if (reg_wr && reg_addr == A_CYC) begin
                if (|reg_wdata[SW-1:NW])          cyc_q <= '1;
                else if (reg_wdata[NW-1:0] == '0) cyc_q <= NW'(1);
                else                              cyc_q <= reg_wdata[NW-1:0];
            end
            if (post) begin
                vrms_q <= vsat[SW-1:0];
                irms_q <= isat[SW-1:0];
                powr_q <= p_neg ? (~pm[SW-1:0] + 1'b1) : pm[SW-1:0];
                engy_q <= p_neg ? (~em[SW-1:0] + 1'b1) : em[SW-1:0];
            end
        end
    end

    assign irq = |(stat_q & mask_q);

    always_comb begin
        unique case (reg_addr_e'(reg_addr))
            A_STAT:  reg_rdata = {{(SW-2){1'b0}}, stat_q};
            A_MASK:  reg_rdata = {{(SW-2){1'b0}}, mask_q};
            A_CYC:   reg_rdata = {{(SW-NW){1'b0}}, cyc_q};
            A_VRMS:  reg_rdata = vrms_q;
            A_IRMS:  reg_rdata = irms_q;
            A_POWR:  reg_rdata = powr_q;
            A_ENGY:  reg_rdata = engy_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

module rms_meter_chk #(
    parameter int SW = 24,
    parameter int NW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic [SW-1:0] reg_wdata,
    input logic [1:0]    stat_q,
    input logic [1:0]    mask_q,
    input logic [NW-1:0] cyc_q,
    input logic [SW-1:0] vrms_q,
    input logic [SW-1:0] irms_q,
    input logic          irq
);
    // R2
    conv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> stat_q[0]);

    // R4
    sticky_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[0] && !(reg_wr && reg_addr == 3'd0 && reg_wdata[0])) |=> stat_q[0]);

    // R4
    sticky_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[1] && !(reg_wr && reg_addr == 3'd0 && reg_wdata[1])) |=> stat_q[1]);

    // R5
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 2'b00) |-> !irq);

    // R11
    atomic_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vrms_q) |-> stat_q[1]);

    // R6
    rms_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vrms_q[SW-1] && !irms_q[SW-1]);

    // R10
    cyc_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_q != '0);
endmodule

bind rms_meter rms_meter_chk #(.SW(SW), .NW(NW)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .stat_q(stat_q),
    .mask_q(mask_q), .cyc_q(cyc_q), .vrms_q(vrms_q), .irms_q(irms_q),
    .irq(irq)
);

// File: tb/sim_rms_meter.sv
`timescale 1ns/1ps
module sim_rms_meter;
    localparam int SW = 24;
    localparam int NW = 16;
    localparam longint FM = (64'd1 << 23) - 1;

    logic clk = 0, rst_n = 0, smp_valid = 0, reg_wr = 0;
    logic signed [SW-1:0] v_smp = '0, i_smp = '0;
    logic [2:0] reg_addr = '0;
    logic [SW-1:0] reg_wdata = '0, reg_rdata;
    logic irq;

    int errors = 0, checks = 0;

    typedef struct { logic [SW-1:0] vr, ir, pw, en; } res_t;
    res_t exp_q[$];

    longint s_vv = 0, s_ii = 0, s_vi = 0;
    int cnt = 0, n_cur = 4, cyc_reg = 4;

    always #2.5 clk = ~clk;

    rms_meter #(.SW(SW), .NW(NW), .DEF_N(4), .E_SHIFT(0)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .v_smp(v_smp),
        .i_smp(i_smp), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [SW-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [SW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic longint isqrt(longint x);
        longint r = longint'($sqrt(real'(x)));
        while (r * r > x) r--;
        while ((r + 1) * (r + 1) <= x) r++;
        return r;
    endfunction

    function automatic logic [SW-1:0] sgn24(bit neg, longint mag);
        return neg ? SW'(-mag) : SW'(mag);
    endfunction

    // driver: sends one pair and pushes expected results at cycle ends
    task automatic samp(int v, int i);
        res_t e;
        longint m;
        bit neg;
        @(negedge clk);
        v_smp = SW'(v); i_smp = SW'(i); smp_valid = 1;
        @(negedge clk);
        smp_valid = 0;
        s_vv += longint'(v) * longint'(v);
        s_ii += longint'(i) * longint'(i);
        s_vi += longint'(v) * longint'(i);
        cnt++;
        if (cnt == n_cur) begin
            m = isqrt(s_vv / n_cur); e.vr = SW'((m > FM) ? FM : m);
            m = isqrt(s_ii / n_cur); e.ir = SW'((m > FM) ? FM : m);
            neg = (s_vi < 0);
            m = ((neg ? -s_vi : s_vi) / n_cur) >>> 23;
            e.pw = sgn24(neg, (m > FM) ? FM : m);
            m = (neg ? -s_vi : s_vi) >>> 23;
            e.en = sgn24(neg, (m > FM) ? FM : m);
            exp_q.push_back(e);
            s_vv = 0; s_ii = 0; s_vi = 0; cnt = 0;
            n_cur = cyc_reg;
        end
        repeat (110) @(negedge clk);
    endtask

    // monitor: pops expected results and compares with posted ones
    task automatic pop_check(string tag);
        res_t e;
        logic [SW-1:0] d;
        rd(3'd0, d);
        check({tag, " R3 data-ready"}, d[1], 1);
        if (exp_q.size() == 0) begin
            check({tag, " R3 queue empty"}, 1, 0);
            return;
        end
        e = exp_q.pop_front();
        rd(3'd3, d); check({tag, " R6 vrms"}, d, e.vr);
        rd(3'd4, d); check({tag, " R6 irms"}, d, e.ir);
        rd(3'd5, d); check({tag, " R7 power"}, d, e.pw);
        rd(3'd6, d); check({tag, " R8 energy"}, d, e.en);
        wr(3'd0, 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [SW-1:0] d, keep;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(3'd0, d); check("R1 status", d, 0);
        rd(3'd1, d); check("R1 mask", d, 0);
        rd(3'd2, d); check("R1 cycle count", d, 4);
        rd(3'd3, d); check("R1 vrms", d, 0);
        rd(3'd6, d); check("R1 energy", d, 0);
        check("R1 irq", irq, 0);

        samp(1 << 22, -(1 << 21));
        rd(3'd0, d); check("R2 conv-ready", d, 1);
        check("R5 irq masked", irq, 0);
        wr(3'd1, 1); #1 check("R5 irq enabled", irq, 1);
        wr(3'd0, 2); rd(3'd0, d); check("R4 clear other bit keeps", d, 1);
        wr(3'd0, 1); rd(3'd0, d); check("R4 clear", d, 0);
        check("R5 irq after clear", irq, 0);
        wr(3'd1, 2);
        samp(1 << 22, -(1 << 21));
        samp(1 << 22, -(1 << 21));
        rd(3'd0, d); check("R3 not before N", d[1], 0);
        check("R5 irq data masked off", irq, 0);
        samp(1 << 22, -(1 << 21));
        #1 check("R5 irq data", irq, 1);
        pop_check("const");

        for (int k = 0; k < 4; k++) samp(-(1 << 23), -(1 << 23));
        pop_check("fullscale");

        samp(8388607, -5000000);
        samp(-3000000, 4000000);
        samp(123456, 7);
        samp(-1, -8388608);
        pop_check("mixed");
        rd(3'd3, keep);

        // R10 cycle count change timing
        wr(3'd2, 0); rd(3'd2, d); check("R10 zero stores one", d, 1);
        wr(3'd2, 24'h10000); rd(3'd2, d); check("R10 clamp", d, 16'hffff);
        samp(5000, 6000);
        wr(3'd2, 3); cyc_reg = 3;
        samp(-7000, 8000);
        samp(9000, -100);
        rd(3'd0, d); check("R10 old N kept", d[1], 0);
        rd(3'd3, d); check("R11 results held", d, keep);
        samp(300000, 400000);
        pop_check("n4");
        samp(2000000, -2000000);
        samp(-1500000, 1000000);
        samp(700000, 700000);
        pop_check("R10 n3");

        // R9 instantaneous mode
        wr(3'd2, 1); cyc_reg = 1;
        samp(10, 20); samp(30, 40); samp(50, 60);
        pop_check("n3 tail");
        samp(-4194304, 2097152);
        pop_check("R9 first");
        samp(1234567, -7654321);
        pop_check("R9 second");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule